// File: doc/BRIEF.md
# Clock Output Divider Tree

This block produces the family of output clocks of a zero-delay clock driver from a single source clock. In normal operation the source is the internal oscillator of the loop; when the loop is bypassed for low-frequency board testing, the source is one of two external reference clocks, picked by a select input. A front-stage control sets whether the double-rate output runs at the source rate or at half of it, and the primary and half-rate outputs follow at fixed ratios of two and four below the double-rate output.

Five primary outputs run in phase with each other, a sixth primary output is their complement, and a half-rate output runs at half the primary frequency. Every divider flip-flop is clocked by the falling edge of the one selected source clock, so all outputs that change on a given step change on the same edge. An active-low asynchronous reset clears every output, and the lock flag from the loop is passed through except in bypass or reset, where it reads low.

Top module: `clkdiv_tree`

## Requirements
- R1: In bypass (`pll_en` = 0), `ref_sel` = 0 selects `ref0_clk` and `ref_sel` = 1 selects `ref1_clk` as the source clock.
- R2: With `pll_en` = 1 the source clock is `osc_clk`; with `pll_en` = 0 it is the selected reference, with no lower limit on its frequency.
- R3: With `freq_sel` = 1, `q_dbl` is the inverse of the source clock, each primary output runs at source/2 and `q_half` at source/4.
- R4: With `freq_sel` = 0, `q_dbl` runs at source/2 (changing on every falling source edge), each primary output at source/4 and `q_half` at source/8.
- R5: All five bits of `q_prim` are equal at all times.
- R6: After the first falling source edge following reset release, `q_inv` is always the complement of `q_prim`.
- R7: Divider outputs change only on falling source edges; after reset release, nothing changes on the first rising edge, and the first falling edge gives `q_prim` = 1 (freq_sel = 1) or `q_dbl` = 1 with `q_prim` = 0 (freq_sel = 0).
- R8: While `rst_n` is low, `q_prim`, `q_inv`, `q_dbl`, `q_half` and `lock_o` all read 0.
- R9: `lock_o` equals `loop_lock` when `pll_en` = 1 and `rst_n` = 1, and is 0 whenever `pll_en` = 0.
- R10: `q_half` changes only on the source edge on which the primary outputs fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock from the loop |
| ref0_clk | input | 1 | External reference clock 0 |
| ref1_clk | input | 1 | External reference clock 1 |
| ref_sel | input | 1 | Reference pick: 0 = ref0_clk, 1 = ref1_clk |
| pll_en | input | 1 | 1 = oscillator drives the tree, 0 = bypass to reference |
| freq_sel | input | 1 | Front stage: 1 = divide by one, 0 = divide by two |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_lock | input | 1 | Lock indication from the loop |
| q_prim | output | 5 | In-phase primary outputs |
| q_inv | output | 1 | Inverted primary output |
| q_dbl | output | 1 | Double-rate output |
| q_half | output | 1 | Half-rate output |
| lock_o | output | 1 | Lock flag, low in bypass or reset |

## Verification
A corrupted divider count shows as a wrong edge count on the double-rate, primary or half-rate output within one window of 64 source periods, and a skipped or extra step breaks the fixed phase between the half-rate and primary outputs on the very next falling edge. A primary copy or the inverted output falling out of step is visible at the next sample after the edge that separated them. A wrong source pick shows as edge counts that do not match the expected reference, and a faulty lock gate is visible at once when bypass is entered with the loop reporting lock.

// File: rtl/clkdiv_tree_pkg.sv
package clkdiv_tree_pkg;

    // Front stage ratio, decoded from the frequency-select input
    typedef enum logic {
        FS_DIV2 = 1'b0,
        FS_DIV1 = 1'b1
    } front_mode_e;

endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel (
    input  logic osc_clk,
    input  logic ref0_clk,
    input  logic ref1_clk,
    input  logic ref_sel,
    input  logic pll_en,
    output logic src_clk
);

    logic ref_clk;

    always_comb begin
        ref_clk = ref_sel ? ref1_clk : ref0_clk;
        src_clk = pll_en ? osc_clk : ref_clk;
    end

endmodule

// File: rtl/div_core.sv
module div_core
    import clkdiv_tree_pkg::*;
#(
    parameter int NUM_PRIM   = 5,
    parameter int DIV_STAGES = 3
) (
    input  logic                src_clk,
    input  logic                rst_n,
    input  front_mode_e         mode,
    output logic [NUM_PRIM-1:0] prim_o,
    output logic                inv_o,
    output logic                dbl_o,
    output logic                half_o
);

    localparam int CNT_W = DIV_STAGES;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic                run;
        logic                dbl;
        logic [NUM_PRIM-1:0] prim;
        logic                inv;
        logic                half;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       prim_bit;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        st_d.run = 1'b1;
        st_d.dbl = st_d.cnt[0];
        if (mode == FS_DIV1) begin
            prim_bit  = st_d.cnt[0];
            st_d.half = st_d.cnt[1];
        end else begin
            prim_bit  = st_d.cnt[1];
            st_d.half = st_d.cnt[2];
        end
        for (int i = 0; i < NUM_PRIM; i++) begin
            st_d.prim[i] = prim_bit;
        end
        st_d.inv = ~prim_bit;
    end

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        prim_o = st_q.prim;
        inv_o  = st_q.inv;
        half_o = st_q.half;
        dbl_o  = (mode == FS_DIV1) ? (~src_clk & rst_n) : st_q.dbl;
    end

    // R5: every primary copy matches copy 0
    p_prim_same_r5: assert property (@(posedge src_clk) disable iff (!rst_n)
        prim_o == {NUM_PRIM{prim_o[0]}});

    // R6: inverted output complements the primaries once running
    p_inv_cpl_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
        st_q.run |-> (inv_o == ~prim_o[0]));

    // R10: half-rate moves only with a falling primary
    p_half_step_r10: assert property (@(posedge src_clk) disable iff (!rst_n)
        $changed(half_o) |-> $fell(prim_o[0]));

    // R4: in divide-by-two mode the double-rate output steps on every falling edge
    p_dbl_step_r4: assert property (@(posedge src_clk) disable iff (!rst_n)
        (mode == FS_DIV2 && $past(mode) == FS_DIV2 && $past(st_q.run)) |-> $changed(dbl_o));

endmodule

// File: rtl/lock_gate.sv
module lock_gate (
    input  logic rst_n,
    input  logic pll_en,
    input  logic loop_lock,
    output logic lock_o
);

    always_comb begin
        lock_o = rst_n & pll_en & loop_lock;
    end

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_tree_pkg::*;
#(
    parameter int NUM_PRIM = 5
) (
    input  logic                osc_clk,
    input  logic                ref0_clk,
    input  logic                ref1_clk,
    input  logic                ref_sel,
    input  logic                pll_en,
    input  logic                freq_sel,
    input  logic                rst_n,
    input  logic                loop_lock,
    output logic [NUM_PRIM-1:0] q_prim,
    output logic                q_inv,
    output logic                q_dbl,
    output logic                q_half,
    output logic                lock_o
);

    localparam int DIV_STAGES = 3;

    logic        src_clk;
    front_mode_e mode;

    assign mode = front_mode_e'(freq_sel);

    clk_src_sel u_src (
        .osc_clk  (osc_clk),
        .ref0_clk (ref0_clk),
        .ref1_clk (ref1_clk),
        .ref_sel  (ref_sel),
        .pll_en   (pll_en),
        .src_clk  (src_clk)
    );

    div_core #(
        .NUM_PRIM   (NUM_PRIM),
        .DIV_STAGES (DIV_STAGES)
    ) u_div (
        .src_clk (src_clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .prim_o  (q_prim),
        .inv_o   (q_inv),
        .dbl_o   (q_dbl),
        .half_o  (q_half)
    );

    lock_gate u_lock (
        .rst_n     (rst_n),
        .pll_en    (pll_en),
        .loop_lock (loop_lock),
        .lock_o    (lock_o)
    );

    // R9: bypass always forces the lock flag low
    p_lock_byp_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !pll_en |-> !lock_o);

endmodule

// File: tb/clkdiv_tree_tb_top.sv
module clkdiv_tree_tb_top;

    logic       osc_clk = 1'b0;
    logic       ref0_clk = 1'b0;
    logic       ref1_clk = 1'b0;
    logic       ref_sel = 1'b0;
    logic       pll_en = 1'b1;
    logic       freq_sel = 1'b1;
    logic       rst_n = 1'b0;
    logic       loop_lock = 1'b0;
    logic [4:0] q_prim;
    logic       q_inv, q_dbl, q_half, lock_o;
    logic       tb_src;

    int n_chk = 0;
    int n_err = 0;
    int e_dbl = 0, e_prim = 0, e_half = 0, e_inv = 0;

    always #10 ref0_clk = ~ref0_clk;   // 50 MHz
    always #26 ref1_clk = ~ref1_clk;
    always #7  osc_clk  = ~osc_clk;

    assign tb_src = pll_en ? osc_clk : (ref_sel ? ref1_clk : ref0_clk);

    always @(posedge q_dbl)     e_dbl  <= e_dbl + 1;
    always @(posedge q_prim[0]) e_prim <= e_prim + 1;
    always @(posedge q_half)    e_half <= e_half + 1;
    always @(posedge q_inv)     e_inv  <= e_inv + 1;

    clkdiv_tree dut_i (
        .osc_clk   (osc_clk),
        .ref0_clk  (ref0_clk),
        .ref1_clk  (ref1_clk),
        .ref_sel   (ref_sel),
        .pll_en    (pll_en),
        .freq_sel  (freq_sel),
        .rst_n     (rst_n),
        .loop_lock (loop_lock),
        .q_prim    (q_prim),
        .q_inv     (q_inv),
        .q_dbl     (q_dbl),
        .q_half    (q_half),
        .lock_o    (lock_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic p, input logic f, input logic r);
        rst_n = 1'b0;
        #30;
        pll_en = p; freq_sel = f; ref_sel = r;
        #60;
        rst_n = 1'b1;
        repeat (4) @(posedge tb_src);
    endtask

    // R8: everything low during reset, lock included
    task automatic t_reset();
        pll_en = 1'b1; freq_sel = 1'b1; loop_lock = 1'b1;
        rst_n = 1'b0;
        repeat (5) @(posedge osc_clk);
        #1;
        chk("R8 prim", int'(q_prim), 0);
        chk("R8 inv", int'(q_inv), 0);
        chk("R8 half", int'(q_half), 0);
        chk("R8 lock", int'(lock_o), 0);
        pll_en = 1'b0; ref_sel = 1'b0;
        @(negedge ref0_clk); #1;
        chk("R8 dbl while reference low", int'(q_dbl), 0);
        loop_lock = 1'b0;
    endtask

    // R1 R2 R3 R4 R5 R6: edge counts over 64 source periods plus phase samples
    task automatic t_ratio(input logic p, input logic f, input logic r, input string tag);
        int s_dbl, s_prim, s_half, s_inv, bad_same, bad_inv;
        apply_cfg(p, f, r);
        @(posedge tb_src); #1;
        s_dbl = e_dbl; s_prim = e_prim; s_half = e_half; s_inv = e_inv;
        bad_same = 0; bad_inv = 0;
        for (int k = 0; k < 64; k++) begin
            @(posedge tb_src); #1;
            if (q_prim != 5'b00000 && q_prim != 5'b11111) bad_same++;
            if (q_inv != ~q_prim[0]) bad_inv++;
        end
        chk({tag, " dbl edges"}, e_dbl - s_dbl, f ? 64 : 32);
        chk({tag, " prim edges"}, e_prim - s_prim, f ? 32 : 16);
        chk({tag, " half edges"}, e_half - s_half, f ? 16 : 8);
        chk({tag, " inv edges"}, e_inv - s_inv, f ? 32 : 16);
        chk({tag, " R5 copies differ"}, bad_same, 0);
        chk({tag, " R6 inv not complement"}, bad_inv, 0);
    endtask

    // R7: first change after release lands on a falling reference edge
    task automatic t_first(input logic f);
        rst_n = 1'b0;
        pll_en = 1'b0; ref_sel = 1'b0; freq_sel = f;
        #40;
        @(negedge ref0_clk); #2;
        rst_n = 1'b1;
        @(posedge ref0_clk); #1;
        chk("R7 prim unchanged on rising edge", int'(q_prim), 0);
        chk("R7 half unchanged on rising edge", int'(q_half), 0);
        @(negedge ref0_clk); #1;
        chk("R7 prim after first falling edge", int'(q_prim), f ? 31 : 0);
        chk("R7 inv after first falling edge", int'(q_inv), f ? 0 : 1);
        if (!f) chk("R7 dbl after first falling edge", int'(q_dbl), 1);
        chk("R7 half after first falling edge", int'(q_half), 0);
    endtask

    // R9: lock pass-through and bypass gating
    task automatic t_lock();
        apply_cfg(1'b1, 1'b1, 1'b0);
        loop_lock = 1'b1; #3;
        chk("R9 lock follows high", int'(lock_o), 1);
        loop_lock = 1'b0; #3;
        chk("R9 lock follows low", int'(lock_o), 0);
        loop_lock = 1'b1; pll_en = 1'b0; #3;
        chk("R9 lock low in bypass", int'(lock_o), 0);
        pll_en = 1'b1; #3;
        chk("R9 lock back after bypass", int'(lock_o), 1);
        loop_lock = 1'b0;
    endtask

    initial begin
        t_reset();
        t_ratio(1'b1, 1'b1, 1'b0, "R2 R3 osc div1");
        t_ratio(1'b1, 1'b0, 1'b0, "R2 R4 osc div2");
        t_ratio(1'b0, 1'b1, 1'b0, "R1 R3 ref0 div1");
        t_ratio(1'b0, 1'b0, 1'b0, "R1 R4 ref0 div2");
        t_ratio(1'b0, 1'b1, 1'b1, "R1 R3 ref1 div1");
        t_ratio(1'b0, 1'b0, 1'b1, "R1 R4 ref1 div2");
        t_ratio(1'b1, 1'b0, 1'b1, "R2 osc ignores ref_sel");
        t_first(1'b1);
        t_first(1'b0);
        t_lock();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule